// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-clock synchronous static memory with a 36-bit word split into four 9-bit byte lanes. Every control, address and write-data input is sampled on the rising clock edge. A cycle can be opened by either of two address strobes. The host strobe is qualified by the primary chip enable. The controller strobe is also honoured when that enable is inactive, and in that case it acts as a deselect. Once a burst is open, a four-beat address sequencer steps through the word addresses in linear or interleaved order, or holds the current address when advance is not requested.

Read data is pipelined through one register stage. The word addressed at one edge is driven on the output after the following edge, as long as the asynchronous output enable is low and snooze is off. Writes take effect at the edge that samples them, with per-lane control. The data bus is modelled as a separate input word, output word and drive flag, so the bus drivers remain outside the block. The memory's cycle timing is fixed and it has no flow control, so no valid/ready handshake appears at its edge.

Top module: `ssram_burst_pipe`

## Requirements
- R1: After reset, `rdata_drive` is 0 and stays 0 until a read has been started.
- R2: A strobe starts a burst only when `ce1_n`=0, `ce2_n`=0 and `ce2`=1. A strobe cycle with `ce1_n`=0 and either of `ce2_n`/`ce2` inactive is a deselect: nothing is written and the bus turns off.
- R3: With `ce1_n`=1, a low `adsp_n` is ignored, and an open burst continues (`adv_n`=0) or suspends (`adv_n`=1) exactly as if no strobe were present.
- R4: A burst opened by `adsp_n` is always a read at that edge, regardless of the write inputs. A write asserted on the following edge, with both strobes high and `adv_n`=1, writes the same address.
- R5: A burst opened by `adsc_n` (with `adsp_n` high) is a write when the write condition holds, and a read otherwise.
- R6: The write condition is `gw_n`=0, or `bwe_n`=0 with at least one `bw_n` bit low. `gw_n`=0 writes all lanes. Otherwise, `bw_n[k]`=0 enables data bits 9k to 9k+8. `bw_n` has no effect while `bwe_n`=1.
- R7: The word read at edge N appears on `rdata`, with `rdata_drive`=1, after edge N+1, and not after edge N.
- R8: In a burst, the low two address bits of beat k are (start+k) mod 4 when `burst_lin`=1, and start XOR k when `burst_lin`=0. `adv_n`=0 moves to the next beat, and `adv_n`=1 repeats the current address.
- R9: `oe_n`=1 forces `rdata_drive` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the pending read word.
- R10: `zz`=1 forces `rdata_drive` to 0. An edge sampled with `zz`=1 writes nothing and starts nothing. The open burst's address and state are kept.
- R11: A deselect at edge N turns `rdata_drive` off after edge N+1 (single-cycle deselect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, captured at a burst start |
| adsp_n | input | 1 | Host address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Secondary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Snooze power-down, active high |
| burst_lin | input | 1 | 1 selects linear burst order, 0 interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data |
| rdata_drive | output | 1 | High when the data bus is driven |

## Verification
A corrupted burst counter or start offset shows up as a wrong word on `rdata` one edge after the beat that used it, so every beat of each burst order is compared. A stale read-pending flag keeps `rdata_drive` high one edge too long after a deselect or snooze, and the bench samples exactly that edge. A wrong lane mask, or a write leaking from a host-strobe start, a disabled chip or a snooze edge, stays hidden until that word is read back. The bench therefore re-reads each guarded address and checks it against its own model.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  typedef struct packed {
    logic start;
    logic kill;
    logic adv;
    op_e  op;
  } cmd_t;
endpackage

// File: rtl/ssram_cmd_decode.sv
module ssram_cmd_decode
  import ssram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             ce1_n,
  input  logic             ce2_n,
  input  logic             ce2,
  input  logic             zz,
  input  logic             burst_on,
  output cmd_t             cmd,
  output logic [LANES-1:0] lane_we
);
  logic             sel;
  logic             wr_cond;
  logic [LANES-1:0] mask;

  always_comb begin
    sel     = !ce1_n && !ce2_n && ce2;
    wr_cond = !gw_n || (!bwe_n && (bw_n != '1));
    if (!gw_n)       mask = '1;
    else if (!bwe_n) mask = ~bw_n;
    else             mask = '0;

    cmd = '0;
    if (zz) begin
      cmd = '0;
    end else if (!adsp_n && !ce1_n) begin
      if (sel) begin
        cmd.start = 1'b1;
        cmd.op    = OP_RD;
      end else begin
        cmd.kill = 1'b1;
      end
    end else if (!adsc_n) begin
      if (sel) begin
        cmd.start = 1'b1;
        cmd.op    = wr_cond ? OP_WR : OP_RD;
      end else begin
        cmd.kill = 1'b1;
      end
    end else if (burst_on) begin
      cmd.op  = wr_cond ? OP_WR : OP_RD;
      cmd.adv = !adv_n;
    end

    lane_we = (cmd.op == OP_WR) ? mask : '0;
  end
endmodule

// File: rtl/ssram_burst_seq.sv
module ssram_burst_seq #(
  parameter int ADDR_W = 6,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              kill,
  input  logic              adv,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              active
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_nx;
  logic [BEAT_W-1:0] beat_sel;
  logic [BEAT_W-1:0] low_bits;

  always_comb begin
    cnt_nx   = cnt_q + 1'b1;
    beat_sel = adv ? cnt_nx : cnt_q;
    low_bits = linear ? (base_q + beat_sel) : (base_q ^ beat_sel);
    eff_addr = start ? addr_in : {upper_q, low_bits};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      active  <= 1'b0;
    end else if (start) begin
      upper_q <= addr_in[ADDR_W-1:BEAT_W];
      base_q  <= addr_in[BEAT_W-1:0];
      cnt_q   <= '0;
      active  <= 1'b1;
    end else if (kill) begin
      active <= 1'b0;
    end else if (adv && active) begin
      cnt_q <= cnt_nx;
    end
  end

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && cnt_q == '0));
  a_r8_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !adv && !start && !kill) |=> $stable(cnt_q));
endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  op_e                     op,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      rd_addr  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_pend  <= (op == OP_RD);
      rd_addr  <= addr;
      rd_drive <= rd_pend;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] q_lane;

    always_ff @(posedge clk) begin
      if (op == OP_WR && lane_we[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       q_lane <= '0;
      else if (rd_pend) q_lane <= store[rd_addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = q_lane;
  end

  a_r7_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> rd_drive);
  a_r11_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pend |=> !rd_drive);
endmodule

// File: rtl/ssram_burst_pipe.sv
module ssram_burst_pipe
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    ce1_n,
  input  logic                    ce2_n,
  input  logic                    ce2,
  input  logic                    oe_n,
  input  logic                    zz,
  input  logic                    burst_lin,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);
  localparam int BEAT_W = 2;

  cmd_t              cmd;
  logic [LANES-1:0]  lane_we;
  logic              burst_on;
  logic [ADDR_W-1:0] eff_addr;
  logic              rd_drive;

  ssram_cmd_decode #(.LANES(LANES)) u_dec (
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .adv_n   (adv_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .ce1_n   (ce1_n),
    .ce2_n   (ce2_n),
    .ce2     (ce2),
    .zz      (zz),
    .burst_on(burst_on),
    .cmd     (cmd),
    .lane_we (lane_we)
  );

  ssram_burst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cmd.start),
    .kill    (cmd.kill),
    .adv     (cmd.adv),
    .linear  (burst_lin),
    .addr_in (addr),
    .eff_addr(eff_addr),
    .active  (burst_on)
  );

  ssram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (cmd.op),
    .addr    (eff_addr),
    .lane_we (lane_we),
    .wdata   (wdata),
    .rdata   (rdata),
    .rd_drive(rd_drive)
  );

  assign rdata_drive = rd_drive && !oe_n && !zz;

  // R2: a burst start requires all three enables active
  a_r2_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.start |-> (!ce1_n && !ce2_n && ce2));
  a_r11_deselect_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.kill |=> ##1 !rd_drive);
  a_r10_snooze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ##1 !rd_drive);
  a_r4_host_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n && !zz) |-> (lane_we == '0));
  a_r2_start_kill_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.start, cmd.kill}));
endmodule

// File: tb/sim_ssram_burst_pipe.sv
module sim_ssram_burst_pipe;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, gw_n, bwe_n;
  logic [NL-1:0] bw_n;
  logic          ce1_n, ce2_n, ce2, oe_n, zz, burst_lin;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_drive;

  logic [DW-1:0] em [64];
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ssram_burst_pipe #(.ADDR_W(AW), .LANES(NL), .LANE_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .ce1_n(ce1_n),
    .ce2_n(ce2_n), .ce2(ce2), .oe_n(oe_n), .zz(zz), .burst_lin(burst_lin),
    .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((64'(a) * 64'h9E3779B97) ^ 64'(salt * 32'h1357));
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    ce1_n = 1; ce2_n = 1; ce2 = 0; zz = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sel_on();
    ce1_n = 0; ce2_n = 0; ce2 = 1;
  endtask

  task automatic start_c(int a, bit wr, logic [DW-1:0] d);
    idle(); sel_on(); adsc_n = 0; addr = AW'(a); gw_n = !wr; wdata = d;
    tick();
    if (wr) em[a] = d;
    idle();
  endtask

  task automatic cont(bit adv, bit wr, logic [DW-1:0] d);
    idle(); adv_n = !adv; gw_n = !wr; wdata = d;
    tick();
    idle();
  endtask

  task automatic desel();
    idle(); adsc_n = 0; ce1_n = 1;
    tick();
    idle();
  endtask

  task automatic wr_burst(int base, int salt);
    start_c(base, 1, pat(base, salt));
    for (int k = 1; k < 4; k++) begin
      cont(1, 1, pat(base + k, salt));
      em[base + k] = pat(base + k, salt);
    end
    desel();
  endtask

  task automatic t_reset();
    chk("R1 drive after reset", DW'(rdata_drive), 0);
    tick(); tick();
    chk("R1 drive idle cycles", DW'(rdata_drive), 0);
  endtask

  task automatic t_ctrl_rw();
    start_c(5, 1, pat(5, 1));
    desel();
    start_c(5, 0, '0);
    chk("R7 not driven after capture edge", DW'(rdata_drive), 0);
    desel();
    chk("R7 drive after next edge", DW'(rdata_drive), 1);
    chk("R5 ctrl write then read", rdata, em[5]);
    tick();
    chk("R11 off after single deselect", DW'(rdata_drive), 0);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] y;
    y = pat(6, 9);
    start_c(6, 1, pat(6, 2));
    desel();
    idle(); sel_on(); adsc_n = 0; addr = 6; bwe_n = 0; bw_n = 4'b1010; wdata = y;
    tick();
    em[6][8:0]   = y[8:0];
    em[6][26:18] = y[26:18];
    idle();
    desel();
    idle(); sel_on(); adsc_n = 0; addr = 6; bwe_n = 1; bw_n = 4'b0000; wdata = ~y;
    tick();
    idle();
    desel();
    chk("R6 lane mask and bw ignored with bwe_n high", rdata, em[6]);
    chk("R6 bw-only cycle read drives", DW'(rdata_drive), 1);
    tick();
  endtask

  task automatic t_enables();
    start_c(7, 1, pat(7, 3));
    desel();
    for (int c = 0; c < 3; c++) begin
      start_c(7, 0, '0);
      idle(); ce1_n = 0; ce2_n = (c == 0); ce2 = (c != 1); addr = 7;
      gw_n = 0; wdata = pat(7, 77);
      if (c == 2) begin adsp_n = 0; ce2 = 0; end
      else adsc_n = 0;
      tick();
      idle();
      chk("R2 read still out", rdata, em[7]);
      tick();
      chk("R2 bad enable deselects", DW'(rdata_drive), 0);
      start_c(7, 0, '0);
      desel();
      chk("R2 bad enable no write", rdata, em[7]);
      tick();
    end
  endtask

  task automatic t_host();
    start_c(8, 1, pat(8, 4));
    desel();
    idle(); sel_on(); adsp_n = 0; addr = 8; gw_n = 0; wdata = pat(8, 55);
    tick();
    idle(); gw_n = 0; wdata = pat(8, 66);
    tick();
    chk("R4 host start reads old word", rdata, em[8]);
    em[8] = pat(8, 66);
    idle();
    desel();
    start_c(8, 0, '0);
    desel();
    chk("R4 write on next edge same address", rdata, em[8]);
    tick();
    burst_lin = 1;
    wr_burst(12, 5);
    start_c(12, 0, '0);
    idle(); adsp_n = 0; ce1_n = 1; adv_n = 0; addr = 40;
    tick();
    idle();
    chk("R3 first beat", rdata, em[12]);
    desel();
    chk("R3 ignored host strobe advances", rdata, em[13]);
    tick();
  endtask

  task automatic t_burst();
    int il [4] = '{17, 16, 19, 18};
    int ln [4] = '{18, 19, 16, 17};
    burst_lin = 1;
    wr_burst(16, 6);
    burst_lin = 0;
    start_c(17, 0, '0);
    for (int k = 0; k < 4; k++) begin
      if (k < 3) cont(1, 0, '0); else desel();
      chk("R8 interleaved beat", rdata, em[il[k]]);
    end
    tick();
    burst_lin = 1;
    start_c(18, 0, '0);
    for (int k = 0; k < 4; k++) begin
      if (k < 3) cont(1, 0, '0); else desel();
      chk("R8 linear beat", rdata, em[ln[k]]);
    end
    tick();
    start_c(18, 0, '0);
    cont(0, 0, '0);
    chk("R8 suspend first", rdata, em[18]);
    cont(1, 0, '0);
    chk("R8 suspend repeats", rdata, em[18]);
    desel();
    chk("R8 advance after suspend", rdata, em[19]);
    tick();
  endtask

  task automatic t_oe();
    start_c(5, 0, '0);
    desel();
    chk("R9 driven", DW'(rdata_drive), 1);
    oe_n = 1; #1;
    chk("R9 oe high forces off", DW'(rdata_drive), 0);
    oe_n = 0; #1;
    chk("R9 oe low restores", DW'(rdata_drive), 1);
    chk("R9 data restored", rdata, em[5]);
    tick();
  endtask

  task automatic t_zz();
    logic [DW-1:0] old21;
    start_c(20, 1, pat(20, 8));
    desel();
    start_c(21, 1, pat(21, 8));
    desel();
    old21 = em[21];
    start_c(20, 0, '0);
    idle(); zz = 1; sel_on(); adsc_n = 0; addr = 21; gw_n = 0; wdata = pat(21, 99);
    tick();
    chk("R10 snooze forces off", DW'(rdata_drive), 0);
    tick();
    chk("R10 snooze holds off", DW'(rdata_drive), 0);
    idle();
    tick();
    chk("R10 no read from snooze edge", DW'(rdata_drive), 0);
    desel();
    chk("R10 burst state kept", rdata, em[20]);
    tick();
    start_c(21, 0, '0);
    desel();
    chk("R10 no write in snooze", rdata, old21);
    tick();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(); addr = '0; wdata = '0; oe_n = 0; burst_lin = 1; rst_n = 0;
    tick(); tick();
    rst_n = 1;
    t_reset();
    t_ctrl_rw();
    t_lanes();
    t_enables();
    t_host();
    t_burst();
    t_oe();
    t_zz();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule